// File: doc/BRIEF.md
# Five-State Multicycle Register CPU

This block is a small processor that steps every instruction through the same five control states: fetch, decode with register read, ALU operation, memory access and register write-back. It then returns to fetch. It holds four 8-bit general-purpose registers, a carry flag, a program counter, an instruction register, a memory address register and a memory data register. The instruction store and the data store are small register arrays kept inside the block.

A program is written into the instruction store through a load port while reset is held. The processor runs once reset is released and stops on a halt instruction. Register contents are read through a combinational debug port. Instructions are 16 bits wide. The opcode sits in bits [15:12]. Bits [11:10] select the first register and bits [9:8] select the second, with 0..3 meaning AX, BX, CX and DX. Bits [7:0] hold an immediate value or a data address.

Top module: `cpu5_top`

## Requirements
- R1: Synchronous reset clears the program counter, the four registers and the carry flag, and deasserts `halted`. It leaves the data store contents unchanged.
- R2: Every instruction other than halt takes exactly five clock cycles. In a program of N such instructions followed by a halt, `halted` first reads 1 after the (5N+2)-th rising edge following reset release.
- R3: Opcode 0 (move immediate) writes bits [7:0] into the register selected by bits [11:10].
- R4: Opcode 3 (add) writes the modulo-256 sum of the first and second registers into the first register and leaves the second unchanged. When both fields name the same register, its value is doubled.
- R5: The carry flag takes bit 8 of the sum on every add. No other opcode changes it.
- R6: Opcode 2 (store) writes the first register into the data store at the address given by the low address bits of [7:0]. Opcode 1 (load) passes that address through the memory address register and writes the stored byte into the first register.
- R7: Opcode F (halt) raises `halted` and freezes the machine. After that, the program counter, the registers and the carry flag stay constant, and no later instruction runs.
- R8: Opcodes 4 to E change no register and no carry, and each takes five cycles like any other instruction.
- R9: The program counter advances by one during each fetch and changes at no other time. After a halt at index N it reads N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| progWe | input | 1 | Instruction store write enable |
| progAddr | input | IMEM_AW | Instruction store write address |
| progData | input | DATA_W+8 | Instruction word to write |
| dbgSel | input | 2 | Register select for debug read (0=AX..3=DX) |
| dbgData | output | DATA_W | Contents of the selected register |
| halted | output | 1 | High once a halt instruction has been decoded |
| pcOut | output | IMEM_AW | Current program counter |
| carryOut | output | 1 | Carry flag |

## Verification
The hardest situation to reach from the ports is a carry out of bit 7 that must then survive later loads, stores and immediate moves unchanged. Close behind it is an add whose two register fields name the same register. Both are reached by writing short programs through the load port during reset. A strided sweep of operand pairs crosses the 255 boundary many times. All sixteen ordered register pairs are driven through an add. The halt cycle count after reset release exposes any state that is skipped or repeated.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ALU,
    ST_MEM,
    ST_WB,
    ST_HALT
  } state_t;

  typedef enum logic [1:0] {
    WB_IMM,
    WB_MEM,
    WB_SUM
  } wbSrc_t;

  typedef struct packed {
    logic   irLoad;
    logic   pcInc;
    logic   opLatch;
    logic   marLoad;
    logic   sumLoad;
    logic   memRead;
    logic   memWrite;
    logic   regWrite;
    logic   carryWrite;
    wbSrc_t wbSrc;
  } strobes_t;

  localparam logic [3:0] OP_MOVI  = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_HALT  = 4'hF;

endpackage

// File: rtl/cpu5_ctrl.sv
module cpu5_ctrl
  import cpu5_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output strobes_t   strobes,
  output state_t     stateNow
);

  state_t stateNext;

  always_comb begin
    case (stateNow)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: stateNext = (opcode == OP_HALT) ? ST_HALT : ST_ALU;
      ST_ALU:    stateNext = ST_MEM;
      ST_MEM:    stateNext = ST_WB;
      ST_WB:     stateNext = ST_FETCH;
      default:   stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateNow <= ST_FETCH;
    else     stateNow <= stateNext;
  end

  always_comb begin
    strobes = '0;
    strobes.wbSrc = WB_SUM;
    case (stateNow)
      ST_FETCH: begin
        strobes.irLoad = 1'b1;
        strobes.pcInc  = 1'b1;
      end
      ST_DECODE: begin
        strobes.opLatch = (opcode != OP_HALT);
      end
      ST_ALU: begin
        strobes.marLoad = (opcode == OP_LOAD) || (opcode == OP_STORE);
        strobes.sumLoad = (opcode == OP_ADD);
      end
      ST_MEM: begin
        strobes.memRead  = (opcode == OP_LOAD);
        strobes.memWrite = (opcode == OP_STORE);
      end
      ST_WB: begin
        case (opcode)
          OP_MOVI: begin
            strobes.regWrite = 1'b1;
            strobes.wbSrc    = WB_IMM;
          end
          OP_LOAD: begin
            strobes.regWrite = 1'b1;
            strobes.wbSrc    = WB_MEM;
          end
          OP_ADD: begin
            strobes.regWrite   = 1'b1;
            strobes.carryWrite = 1'b1;
            strobes.wbSrc      = WB_SUM;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu5_datapath.sv
module cpu5_datapath
  import cpu5_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int IMEM_AW = 4,
  parameter  int DMEM_AW = 4,
  localparam int INSTR_W = DATA_W + 8
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic               progWe,
  input  logic [IMEM_AW-1:0] progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic [1:0]         dbgSel,
  output logic [DATA_W-1:0]  dbgData,
  output logic [3:0]         opcode,
  output logic [IMEM_AW-1:0] pcOut,
  output logic               carryOut
);

  localparam int REG_CNT    = 4;
  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int DMEM_DEPTH = 1 << DMEM_AW;

  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [DATA_W-1:0]  dmem [DMEM_DEPTH];
  logic [DATA_W-1:0]  regFile [REG_CNT];

  logic [IMEM_AW-1:0] pc;
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  mar;
  logic [DATA_W-1:0]  mdr;
  logic [DATA_W-1:0]  opA;
  logic [DATA_W-1:0]  opB;
  logic [DATA_W:0]    sumReg;
  logic               carry;
  logic [DATA_W-1:0]  wbVal;

  logic [1:0]         regFirst;
  logic [1:0]         regSecond;
  logic [DATA_W-1:0]  immField;

  assign opcode    = ir[INSTR_W-1 -: 4];
  assign regFirst  = ir[DATA_W+3 -: 2];
  assign regSecond = ir[DATA_W+1 -: 2];
  assign immField  = ir[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (progWe) imem[progAddr] <= progData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else if (strobes.irLoad) begin
      ir <= imem[pc];
      if (strobes.pcInc) pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
    end else if (strobes.opLatch) begin
      opA <= regFile[regFirst];
      opB <= regFile[regSecond];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar    <= '0;
      sumReg <= '0;
    end else begin
      if (strobes.marLoad) mar <= immField;
      if (strobes.sumLoad) sumReg <= {1'b0, opA} + {1'b0, opB};
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.memWrite) dmem[mar[DMEM_AW-1:0]] <= opA;
  end

  always_ff @(posedge clk) begin
    if (rst)                  mdr <= '0;
    else if (strobes.memRead) mdr <= dmem[mar[DMEM_AW-1:0]];
  end

  always_comb begin
    case (strobes.wbSrc)
      WB_IMM:  wbVal = immField;
      WB_MEM:  wbVal = mdr;
      default: wbVal = sumReg[DATA_W-1:0];
    endcase
  end

  generate
    for (genvar g = 0; g < REG_CNT; g++) begin : gReg
      always_ff @(posedge clk) begin
        if (rst) regFile[g] <= '0;
        else if (strobes.regWrite && (regFirst == 2'(g))) regFile[g] <= wbVal;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                     carry <= 1'b0;
    else if (strobes.carryWrite) carry <= sumReg[DATA_W];
  end

  assign dbgData  = regFile[dbgSel];
  assign pcOut    = pc;
  assign carryOut = carry;

endmodule

// File: rtl/cpu5_top.sv
module cpu5_top
  import cpu5_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int IMEM_AW = 4,
  parameter  int DMEM_AW = 4,
  localparam int INSTR_W = DATA_W + 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progWe,
  input  logic [IMEM_AW-1:0] progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic [1:0]         dbgSel,
  output logic [DATA_W-1:0]  dbgData,
  output logic               halted,
  output logic [IMEM_AW-1:0] pcOut,
  output logic               carryOut
);

  strobes_t   strobes;
  state_t     stateNow;
  logic [3:0] opcode;

  cpu5_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .strobes  (strobes),
    .stateNow (stateNow)
  );

  cpu5_datapath #(
    .DATA_W  (DATA_W),
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .dbgSel   (dbgSel),
    .dbgData  (dbgData),
    .opcode   (opcode),
    .pcOut    (pcOut),
    .carryOut (carryOut)
  );

  assign halted = (stateNow == ST_HALT);

endmodule

// File: rtl/cpu5_checker.sv
module cpu5_checker
  import cpu5_pkg::*;
#(
  parameter int IMEM_AW = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               halted,
  input logic [IMEM_AW-1:0] pcOut,
  input logic               carryOut,
  input state_t             stateNow
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pcOut == '0) && !halted && !carryOut);

  p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_FETCH) |=> (stateNow == ST_DECODE));

  p_decode_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_DECODE) |=> (stateNow == ST_ALU) || (stateNow == ST_HALT));

  p_alu_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_ALU) |=> (stateNow == ST_MEM));

  p_mem_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_MEM) |=> (stateNow == ST_WB));

  p_wb_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_WB) |=> (stateNow == ST_FETCH));

  p_carry_wb_only_r5: assert property (@(posedge clk) disable iff (rst)
    (stateNow != ST_WB) |=> $stable(carryOut));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_pc_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pcOut));

  p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
    (stateNow == ST_FETCH) |=> (pcOut == IMEM_AW'($past(pcOut) + 1'b1)));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stateNow != ST_FETCH) |=> $stable(pcOut));

endmodule

bind cpu5_top cpu5_checker #(.IMEM_AW(IMEM_AW)) chk (
  .clk      (clk),
  .rst      (rst),
  .halted   (halted),
  .pcOut    (pcOut),
  .carryOut (carryOut),
  .stateNow (stateNow)
);

// File: tb/cpu5_top_test.sv
module cpu5_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progWe = 1'b0;
  logic [3:0]  progAddr = '0;
  logic [15:0] progData = '0;
  logic [1:0]  dbgSel = '0;
  logic [7:0]  dbgData;
  logic        halted;
  logic [3:0]  pcOut;
  logic        carryOut;

  int total = 0;
  int bad = 0;
  logic [15:0] prog [16];
  int cycles;

  always #10 clk = ~clk;

  cpu5_top uut (
    .clk      (clk),
    .rst      (rst),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .dbgSel   (dbgSel),
    .dbgData  (dbgData),
    .halted   (halted),
    .pcOut    (pcOut),
    .carryOut (carryOut)
  );

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] ra,
                                      input logic [1:0] rb, input logic [7:0] imm);
    return {op, ra, rb, imm};
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic getReg(input int idx, output logic [7:0] v);
    dbgSel = 2'(idx);
    #1;
    v = dbgData;
  endtask

  task automatic checkReg(input string tag, input int idx, input int expected);
    logic [7:0] v;
    getReg(idx, v);
    check(tag, int'(v), expected);
  endtask

  // Loads prog (unused words = halt) under reset, then runs until halted.
  task automatic runProg();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      progWe = 1'b1;
      progAddr = 4'(i);
      progData = prog[i];
      @(negedge clk);
    end
    progWe = 1'b0;
    rst = 1'b0;
    cycles = 0;
    while (!halted && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 16'hF000;
  endtask

  initial begin
    #(20ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] vals [4];
    int exp4 [4];

    // Immediate moves, timing and pc (R3, R2, R9)
    clearProg();
    prog[0] = enc(4'h0, 2'd0, 2'd0, 8'h12);
    prog[1] = enc(4'h0, 2'd1, 2'd0, 8'h34);
    prog[2] = enc(4'h0, 2'd2, 2'd0, 8'hFF);
    prog[3] = enc(4'h0, 2'd3, 2'd0, 8'h01);
    runProg();
    check("R2 halt cycle count", cycles, 22);
    check("R9 pc after halt", int'(pcOut), 5);
    checkReg("R3 AX imm", 0, 8'h12);
    checkReg("R3 BX imm", 1, 8'h34);
    checkReg("R3 CX imm", 2, 8'hFF);
    checkReg("R3 DX imm", 3, 8'h01);

    // ADD operand sweep (R4, R5)
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        clearProg();
        prog[0] = enc(4'h0, 2'd0, 2'd0, 8'(a));
        prog[1] = enc(4'h0, 2'd1, 2'd0, 8'(b));
        prog[2] = enc(4'h3, 2'd0, 2'd1, 8'h00);
        runProg();
        checkReg("R4 sum in first reg", 0, (a + b) % 256);
        checkReg("R4 second reg kept", 1, b);
        check("R5 carry from add", int'(carryOut), (a + b) / 256);
      end
    end
    check("R2 add program cycles", cycles, 17);

    // All register pairs (R4)
    for (int r1 = 0; r1 < 4; r1++) begin
      for (int r2 = 0; r2 < 4; r2++) begin
        clearProg();
        exp4[0] = 8'h11; exp4[1] = 8'h22; exp4[2] = 8'h44; exp4[3] = 8'h88;
        for (int k = 0; k < 4; k++) prog[k] = enc(4'h0, 2'(k), 2'd0, 8'(exp4[k]));
        prog[4] = enc(4'h3, 2'(r1), 2'(r2), 8'h00);
        runProg();
        exp4[r1] = (exp4[r1] + exp4[r2]) % 256;
        for (int k = 0; k < 4; k++) checkReg("R4 register pair", k, exp4[k]);
      end
    end

    // Carry held through non-add ops, then cleared by a no-carry add (R5)
    clearProg();
    prog[0] = enc(4'h0, 2'd0, 2'd0, 8'hF0);
    prog[1] = enc(4'h0, 2'd1, 2'd0, 8'h20);
    prog[2] = enc(4'h3, 2'd0, 2'd1, 8'h00);
    prog[3] = enc(4'h0, 2'd2, 2'd0, 8'h05);
    prog[4] = enc(4'h2, 2'd2, 2'd0, 8'h03);
    prog[5] = enc(4'h1, 2'd3, 2'd0, 8'h03);
    runProg();
    check("R5 carry kept after mov/store/load", int'(carryOut), 1);
    checkReg("R4 wrapped sum", 0, 8'h10);
    prog[6] = enc(4'h0, 2'd3, 2'd0, 8'h01);
    prog[7] = enc(4'h3, 2'd3, 2'd3, 8'h00);
    runProg();
    check("R5 carry cleared by add", int'(carryOut), 0);
    checkReg("R4 doubled DX", 3, 2);

    // Store then load at every address (R6)
    for (int ad = 0; ad < 16; ad++) begin
      clearProg();
      prog[0] = enc(4'h0, 2'd2, 2'd0, 8'((ad * 7 + 3) % 256));
      prog[1] = enc(4'h2, 2'd2, 2'd0, 8'(ad));
      prog[2] = enc(4'h1, 2'd3, 2'd0, 8'(ad));
      runProg();
      checkReg("R6 load after store", 3, (ad * 7 + 3) % 256);
    end
    // Data store survives reset (R6, R1)
    clearProg();
    prog[0] = enc(4'h1, 2'd0, 2'd0, 8'd5);
    prog[1] = enc(4'h1, 2'd1, 2'd0, 8'd9);
    runProg();
    checkReg("R6 R1 data kept over reset addr5", 0, 38);
    checkReg("R6 R1 data kept over reset addr9", 1, 66);

    // Halt freeze (R7)
    clearProg();
    prog[0] = enc(4'h0, 2'd0, 2'd0, 8'h01);
    prog[1] = 16'hF000;
    prog[2] = enc(4'h0, 2'd0, 2'd0, 8'h99);
    prog[3] = enc(4'h0, 2'd1, 2'd0, 8'h55);
    runProg();
    repeat (20) @(negedge clk);
    check("R7 halted held", int'(halted), 1);
    check("R7 pc frozen", int'(pcOut), 2);
    checkReg("R7 AX not overwritten", 0, 8'h01);
    checkReg("R7 BX not written", 1, 8'h00);

    // Unused opcodes (R8)
    clearProg();
    prog[0] = enc(4'h0, 2'd0, 2'd0, 8'h07);
    prog[1] = enc(4'h5, 2'd0, 2'd0, 8'h33);
    prog[2] = enc(4'hE, 2'd0, 2'd1, 8'h44);
    runProg();
    check("R8 unused opcode cycles", cycles, 17);
    checkReg("R8 AX unchanged", 0, 8'h07);
    checkReg("R8 BX unchanged", 1, 8'h00);
    check("R8 carry unchanged", int'(carryOut), 0);

    // Reset clears state (R1): first leave carry and registers set
    clearProg();
    prog[0] = enc(4'h0, 2'd0, 2'd0, 8'hFF);
    prog[1] = enc(4'h3, 2'd0, 2'd0, 8'h00);
    runProg();
    check("R1 precondition carry", int'(carryOut), 1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pc cleared", int'(pcOut), 0);
    check("R1 halted low", int'(halted), 0);
    check("R1 carry cleared", int'(carryOut), 0);
    for (int k = 0; k < 4; k++) checkReg("R1 register cleared", k, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule